// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This controller takes a byte-wide parallel flash array through a full chip erase with per-byte verification. A single start pulse begins the sequence. The controller first reads the whole array to confirm that every byte holds zero. If any byte does not, it asks an external programming engine to clear the array before going on. It then requests the high programming supply and waits for the supply ramp to report completion. After that it issues pairs of erase command writes, waits out the erase time, and verifies the array one address at a time.

Each verify step writes the verify command to the byte under test, waits the settling time, and reads the byte back. A byte that reads as all ones moves the scan to the next address. A byte that does not triggers another erase pulse, and the scan resumes at that same address. The sequence ends in one of two ways. If the last address passes, the controller writes the read-mode command, lowers the supply and reports success. If the pulse budget runs out, it lowers the supply and reports an error.

All waits are whole clock cycles derived from the clock frequency parameter, rounded up. A one-cycle done or error pulse marks the end of a run, and a sticky pass or fail flag holds the outcome until the next accepted start.

Top module: `flash_erase_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `error_o`, both sticky flags, `prog_req_o`, `vpp_hi_o`, `flash_we_o` and `flash_oe_o` are all low.
- R2: A `start_i` pulse seen while idle makes `busy_o` high from the next cycle and clears both sticky flags. A `start_i` seen while busy has no effect on the running sequence. The idle cycle in which `done_o` pulses counts as idle.
- R3: The pre-check reads addresses upward from 0, one `flash_oe_o` cycle each. At the first byte that is not 00h it stops reading, raises `prog_req_o` with `vpp_hi_o` low, and holds the request until `prog_done_i`. If every byte is 00h, no request is made.
- R4: `vpp_hi_o` rises next, and no flash write occurs until `vpp_ramp_done_i` has pulsed. Every write strobe happens while `vpp_hi_o` is high.
- R5: An erase pulse is two writes of data 20h. After the second write's hold cycle, the controller waits ERASE_US*CLK_MHZ cycles. With the next write's setup cycle, `flash_we_o` is therefore low for ERASE_US*CLK_MHZ+2 cycles.
- R6: Verify writes data A0h to the address under test. After that write's hold cycle, the controller waits ceil(VERIFY_NS*CLK_MHZ/1000) cycles and then reads with `flash_oe_o` for one cycle.
- R7: A read of FFh advances the address. Verify addresses never decrease within a run.
- R8: A read that is not FFh issues a new erase pulse. Verify then resumes at the same address, not at address 0.
- R9: After MAX_PULSES erase pulses, a failing verify lowers `vpp_hi_o` without writing the read command. After the ramp-done pulse, `error_o` pulses and `fail_flag_o` sets.
- R10: When the last address passes, the controller writes 00h, lowers `vpp_hi_o` and waits for `vpp_ramp_done_i`. Then `done_o` pulses and `pass_flag_o` sets.
- R11: Each write holds `flash_we_o` high for exactly WE_CYC cycles. Address and data are stable in the cycle before the strobe, throughout it, and in the cycle after it. `flash_we_o` and `flash_oe_o` are never high together.
- R12: `done_o` and `error_o` are single-cycle pulses and never high together. The sticky flags hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful erase |
| error_o | output | 1 | One-cycle pulse when the pulse budget is exhausted |
| pass_flag_o | output | 1 | Sticky success flag |
| fail_flag_o | output | 1 | Sticky failure flag |
| prog_req_o | output | 1 | Request to program the whole array to 00h |
| prog_done_i | input | 1 | Programming engine finished (pulse) |
| vpp_hi_o | output | 1 | Request for the high programming supply |
| vpp_ramp_done_i | input | 1 | Supply reached the requested level (pulse) |
| flash_addr_o | output | ADDR_W | Flash byte address |
| flash_wdata_o | output | 8 | Command byte for writes |
| flash_rdata_i | input | 8 | Byte read from the flash |
| flash_we_o | output | 1 | Write strobe |
| flash_oe_o | output | 1 | Read strobe |

## Verification
The completion pulse and a new start request can fall in the same cycle. `done_o` is high during the first idle cycle, so a start asserted in that cycle must be accepted. The bench waits for `done_o`, raises `start_i` in that cycle, and then checks three things: `busy_o` is high on the next cycle, `pass_flag_o` has cleared, and the second run finishes with another `done_o`. A separate run pulses `start_i` part way through a sequence. It then confirms that the pulse count, the verify count and the programming-request count are exactly those of an undisturbed run.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RD, S_PROG, S_VPP_UP, S_ER_SETUP, S_ER_CMD, S_ER_WAIT,
    S_VF_CMD, S_VF_WAIT, S_VF_RD, S_RD_CMD, S_VPP_DN
  } seq_state_e;

  typedef enum logic [1:0] {WR_IDLE, WR_SETUP, WR_STROBE, WR_HOLD} wr_phase_e;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_VERIFY  = 8'hA0;
  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;
endpackage

// File: rtl/flash_bus_wr.sv
module flash_bus_wr
  import flash_erase_pkg::*;
#(
  parameter int unsigned WE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic we_o,
  output logic done_o
);
  localparam int unsigned CW = (WE_CYC > 1) ? $clog2(WE_CYC) : 1;
  localparam logic [CW-1:0] STROBE_LAST = CW'(WE_CYC - 1);

  wr_phase_e     phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= WR_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        WR_IDLE:   if (go_i) phase_q <= WR_SETUP;
        WR_SETUP: begin
          phase_q <= WR_STROBE;
          cnt_q   <= STROBE_LAST;
        end
        WR_STROBE: begin
          if (cnt_q == '0) phase_q <= WR_HOLD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        WR_HOLD:   phase_q <= go_i ? WR_SETUP : WR_IDLE;
        default:   phase_q <= WR_IDLE;
      endcase
    end
  end

  assign we_o   = (phase_q == WR_STROBE);
  assign done_o = (phase_q == WR_HOLD);
endmodule

// File: rtl/flash_wait_tmr.sv
module flash_wait_tmr #(
  parameter int unsigned LONG_CYC  = 16,
  parameter int unsigned SHORT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic sel_long_i,
  output logic done_o
);
  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] LONG_V  = W'(LONG_CYC);
  localparam logic [W-1:0] SHORT_V = W'(SHORT_CYC);
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (go_i)            cnt_q <= sel_long_i ? LONG_V : SHORT_V;
    else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end

  // loaded value N gives exactly N cycles in the waiting state
  assign done_o = (cnt_q == ONE);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned ERASE_US   = 10000,
  parameter int unsigned VERIFY_NS  = 6000,
  parameter int unsigned WE_CYC     = 2,
  parameter int unsigned MAX_PULSES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              pass_flag_o,
  output logic              fail_flag_o,
  output logic              prog_req_o,
  input  logic              prog_done_i,
  output logic              vpp_hi_o,
  input  logic              vpp_ramp_done_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [7:0]        flash_wdata_o,
  input  logic [7:0]        flash_rdata_i,
  output logic              flash_we_o,
  output logic              flash_oe_o
);
  localparam int unsigned ERASE_CYC  = ERASE_US * CLK_MHZ;
  localparam int unsigned VERIFY_CYC = (VERIFY_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned PCNT_W     = $clog2(MAX_PULSES + 1);
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(MAX_PULSES - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wdata_q, wdata_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic              vpp_q, vpp_d;
  logic              fail_path_q, fail_path_d;
  logic              done_q, done_d, err_q, err_d;
  logic              pass_q, pass_d, fail_q, fail_d;
  logic              wr_go, wr_done, tmr_go, tmr_done;

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    wdata_d     = wdata_q;
    pcnt_d      = pcnt_q;
    vpp_d       = vpp_q;
    fail_path_d = fail_path_q;
    pass_d      = pass_q;
    fail_d      = fail_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_PRE_RD;
        addr_d  = '0;
        pass_d  = 1'b0;
        fail_d  = 1'b0;
      end
      S_PRE_RD: begin
        if (flash_rdata_i != BYTE_ZERO) state_d = S_PROG;
        else if (addr_q == LAST_ADDR) begin
          state_d = S_VPP_UP;
          vpp_d   = 1'b1;
        end else addr_d = addr_q + 1'b1;
      end
      S_PROG: if (prog_done_i) begin
        state_d = S_VPP_UP;
        vpp_d   = 1'b1;
      end
      S_VPP_UP: if (vpp_ramp_done_i) begin
        state_d = S_ER_SETUP;
        addr_d  = '0;
        pcnt_d  = '0;
        wdata_d = CMD_ERASE;
      end
      S_ER_SETUP: if (wr_done) state_d = S_ER_CMD;
      S_ER_CMD:   if (wr_done) state_d = S_ER_WAIT;
      S_ER_WAIT: if (tmr_done) begin
        state_d = S_VF_CMD;
        wdata_d = CMD_VERIFY;
      end
      S_VF_CMD:  if (wr_done)  state_d = S_VF_WAIT;
      S_VF_WAIT: if (tmr_done) state_d = S_VF_RD;
      S_VF_RD: begin
        if (flash_rdata_i == BYTE_ERASED) begin
          if (addr_q == LAST_ADDR) begin
            state_d = S_RD_CMD;
            wdata_d = CMD_READ;
          end else begin
            state_d = S_VF_CMD;
            addr_d  = addr_q + 1'b1;
          end
        end else begin
          pcnt_d = pcnt_q + 1'b1;
          if (pcnt_q == PCNT_LAST) begin
            state_d     = S_VPP_DN;
            vpp_d       = 1'b0;
            fail_path_d = 1'b1;
          end else begin
            state_d = S_ER_SETUP;
            wdata_d = CMD_ERASE;
          end
        end
      end
      S_RD_CMD: if (wr_done) begin
        state_d     = S_VPP_DN;
        vpp_d       = 1'b0;
        fail_path_d = 1'b0;
      end
      S_VPP_DN: if (vpp_ramp_done_i) begin
        state_d = S_IDLE;
        if (fail_path_q) begin
          err_d  = 1'b1;
          fail_d = 1'b1;
        end else begin
          done_d = 1'b1;
          pass_d = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // write and timer launches on entry to their states
  assign wr_go  = (state_d != state_q) &&
                  (state_d inside {S_ER_SETUP, S_ER_CMD, S_VF_CMD, S_RD_CMD});
  assign tmr_go = (state_d != state_q) && (state_d inside {S_ER_WAIT, S_VF_WAIT});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      pcnt_q      <= '0;
      vpp_q       <= 1'b0;
      fail_path_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      addr_q      <= addr_d;
      wdata_q     <= wdata_d;
      pcnt_q      <= pcnt_d;
      vpp_q       <= vpp_d;
      fail_path_q <= fail_path_d;
      done_q      <= done_d;
      err_q       <= err_d;
      pass_q      <= pass_d;
      fail_q      <= fail_d;
    end
  end

  flash_bus_wr #(.WE_CYC(WE_CYC)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (wr_go),
    .we_o   (flash_we_o),
    .done_o (wr_done)
  );

  flash_wait_tmr #(.LONG_CYC(ERASE_CYC), .SHORT_CYC(VERIFY_CYC)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (tmr_go),
    .sel_long_i (state_d == S_ER_WAIT),
    .done_o     (tmr_done)
  );

  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = done_q;
  assign error_o       = err_q;
  assign pass_flag_o   = pass_q;
  assign fail_flag_o   = fail_q;
  assign prog_req_o    = (state_q == S_PROG);
  assign vpp_hi_o      = vpp_q;
  assign flash_addr_o  = addr_q;
  assign flash_wdata_o = wdata_q;
  assign flash_oe_o    = (state_q == S_PRE_RD) || (state_q == S_VF_RD);
endmodule

// File: rtl/flash_erase_sva.sv
module flash_erase_sva #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              pass_flag_o,
  input logic              fail_flag_o,
  input logic              prog_req_o,
  input logic              prog_done_i,
  input logic              vpp_hi_o,
  input logic              vpp_ramp_done_i,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [7:0]        flash_wdata_o,
  input logic [7:0]        flash_rdata_i,
  input logic              flash_we_o,
  input logic              flash_oe_o
);
  a_r1_idle_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !flash_we_o && !flash_oe_o && !vpp_hi_o);

  a_r2_start_clears_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !pass_flag_o && !fail_flag_o);

  a_r3_prog_with_vpp_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> !vpp_hi_o && !flash_we_o && !flash_oe_o);

  a_r4_write_needs_vpp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> vpp_hi_o);

  a_r11_stable_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> $stable(flash_addr_o) && $stable(flash_wdata_o));

  a_r11_stable_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_we_o) |-> $stable(flash_addr_o) && $stable(flash_wdata_o));

  a_r11_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_we_o && flash_oe_o));

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);

  a_r12_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  a_r10_done_sets_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pass_flag_o && !busy_o && !vpp_hi_o);

  a_r9_err_sets_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> fail_flag_o && !busy_o && !vpp_hi_o);

  a_r12_flags_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(pass_flag_o) && $stable(fail_flag_o));
endmodule

bind flash_erase_seq flash_erase_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned WE_CYC = 3;
  localparam int unsigned NADDR  = 1 << ADDR_W;
  localparam int ER_GAP = 1 + 250 + 1;  // hold + 1us*250MHz + setup
  localparam int VF_GAP = 1 + 6;        // hold + ceil(21ns*250MHz)

  // pre_dirty, hard_addr, hard_need, exp_prog, exp_pulses, exp_err, exp_verifies
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{0, 0,  1, 0, 1, 0, 16},
    '{1, 7,  3, 1, 3, 0, 18},
    '{0, 15, 5, 0, 5, 0, 20},
    '{1, 3,  6, 1, 5, 1, 8},
    '{0, 0,  2, 0, 2, 0, 17}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, err, pass_f, fail_f, prog_req, vpp_hi, we, oe;
  logic prog_done = 1'b0, ramp_done = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, rdata;

  always #2 clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(ADDR_W), .CLK_MHZ(250), .ERASE_US(1), .VERIFY_NS(21),
    .WE_CYC(WE_CYC), .MAX_PULSES(5)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .error_o(err), .pass_flag_o(pass_f), .fail_flag_o(fail_f),
    .prog_req_o(prog_req), .prog_done_i(prog_done), .vpp_hi_o(vpp_hi),
    .vpp_ramp_done_i(ramp_done), .flash_addr_o(addr), .flash_wdata_o(wdata),
    .flash_rdata_i(rdata), .flash_we_o(we), .flash_oe_o(oe)
  );

  // flash array model
  logic [7:0] mem [NADDR];
  int need [NADDR];
  logic clr = 1'b0;
  logic programmed, we_q, oe_q, prog_q, vpp_q, have_a0;
  int n20, na0, nprog, ndone, lowcnt, wcnt, er_gap, vf_gap, pcyc, rcnt;
  int order_err, width_err, novpp_err;
  logic [7:0] last_wr;
  logic [ADDR_W-1:0] last_a0_addr;

  assign rdata = ((n20 / 2) >= need[addr]) ? 8'hFF : (programmed ? 8'h00 : mem[addr]);

  always @(negedge clk) begin
    if (clr) begin
      programmed <= 0; we_q <= 0; oe_q <= 0; prog_q <= 0; vpp_q <= 0; have_a0 <= 0;
      n20 <= 0; na0 <= 0; nprog <= 0; ndone <= 0; lowcnt <= 0; wcnt <= 0;
      er_gap <= -1; vf_gap <= -1; pcyc <= 0; rcnt <= 0;
      order_err <= 0; width_err <= 0; novpp_err <= 0; last_wr <= 8'h55;
      last_a0_addr <= '0; prog_done <= 0; ramp_done <= 0;
    end else begin
      we_q <= we; oe_q <= oe; prog_q <= prog_req; vpp_q <= vpp_hi;
      if (we) begin
        lowcnt <= 0;
        wcnt <= wcnt + 1;
        if (!we_q) begin
          last_wr <= wdata;
          if (wdata == 8'h20) n20 <= n20 + 1;
          if (wdata == 8'hA0) begin
            na0 <= na0 + 1;
            if (have_a0 && addr < last_a0_addr) order_err <= order_err + 1;
            last_a0_addr <= addr;
            have_a0 <= 1;
            if (last_wr == 8'h20) er_gap <= lowcnt;
          end
          if (!vpp_hi || rcnt != 0) novpp_err <= novpp_err + 1;
        end
      end else begin
        lowcnt <= lowcnt + 1;
        if (we_q) begin
          if (wcnt != WE_CYC) width_err <= width_err + 1;
          wcnt <= 0;
        end
        if (oe && !oe_q && last_wr == 8'hA0) vf_gap <= lowcnt;
      end
      if (prog_req && !prog_q) nprog <= nprog + 1;
      if (prog_req) begin
        pcyc <= pcyc + 1;
        if (pcyc == 9) begin programmed <= 1; prog_done <= 1; end
        else prog_done <= 0;
      end else begin
        pcyc <= 0; prog_done <= 0;
      end
      if (vpp_hi != vpp_q) rcnt <= 8;
      else if (rcnt != 0) rcnt <= rcnt - 1;
      ramp_done <= (vpp_hi == vpp_q) && (rcnt == 1);
      if (done || err) ndone <= ndone + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic setup_case(input int dirty, input int haddr, input int hneed);
    for (int a = 0; a < NADDR; a++) begin
      mem[a]  = 8'h00;
      need[a] = 1;
    end
    if (dirty != 0) mem[5] = 8'h3C;
    need[haddr] = hneed;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output logic got_err);
    while (!(done || err)) @(negedge clk);
    got_err = err;
    @(negedge clk);
  endtask

  task automatic check_run(input int i, input logic got_err);
    chk($sformatf("R9/R10 case%0d outcome", i), int'(got_err), VEC[i][5]);
    chk($sformatf("R3 case%0d prog requests", i), nprog, VEC[i][3]);
    chk($sformatf("R5/R9 case%0d erase pulses", i), n20 / 2, VEC[i][4]);
    chk($sformatf("R5 case%0d writes paired", i), n20 % 2, 0);
    chk($sformatf("R7/R8 case%0d verify writes", i), na0, VEC[i][6]);
    chk($sformatf("R7 case%0d address order", i), order_err, 0);
    chk($sformatf("R11 case%0d strobe width", i), width_err, 0);
    chk($sformatf("R4 case%0d writes under vpp", i), novpp_err, 0);
    chk($sformatf("R5 case%0d erase wait", i), er_gap, ER_GAP);
    chk($sformatf("R6 case%0d verify wait", i), vf_gap, VF_GAP);
    chk($sformatf("R9/R10 case%0d final write", i), int'(last_wr),
        (VEC[i][5] != 0) ? 32'hA0 : 32'h00);
    chk($sformatf("R10 case%0d vpp low", i), int'(vpp_hi), 0);
    chk($sformatf("R12 case%0d pass flag", i), int'(pass_f), (VEC[i][5] != 0) ? 0 : 1);
    chk($sformatf("R12 case%0d fail flag", i), int'(fail_f), VEC[i][5]);
    chk($sformatf("R12 case%0d one end pulse", i), ndone, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog R2 act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic got_err;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 strobes in reset", int'(we | oe | vpp_hi | prog_req), 0);
    chk("R1 status in reset", int'(done | err | pass_f | fail_f), 0);
    rst_n = 1'b1;
    clr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(busy | vpp_hi | pass_f | fail_f), 0);

    for (int i = 0; i < NV; i++) begin
      setup_case(VEC[i][0], VEC[i][1], VEC[i][2]);
      pulse_start();
      chk($sformatf("R2 case%0d busy", i), int'(busy), 1);
      wait_end(got_err);
      check_run(i, got_err);
      repeat (5) @(negedge clk);
      chk($sformatf("R12 case%0d flags held", i), int'(pass_f) + 2 * int'(fail_f),
          (VEC[i][5] != 0) ? 2 : 1);
    end

    // start while busy is ignored: same counts as an undisturbed vector 1 run
    setup_case(VEC[1][0], VEC[1][1], VEC[1][2]);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_end(got_err);
    check_run(1, got_err);

    // start in the very cycle done pulses
    setup_case(0, 2, 1);
    pulse_start();
    while (!done) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 start on done accepted", int'(busy), 1);
    chk("R2 pass flag cleared", int'(pass_f), 0);
    wait_end(got_err);
    chk("R10 second run succeeds", int'(got_err), 0);
    chk("R10 second run pass flag", int'(pass_f), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule